// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

A synchronous 1024 x 8 memory with two fully independent ports, left and right. Each port has its own enable, output enable, write select, 10-bit address and 8-bit write and read data. Each port can read or write any word in any cycle. Writes commit on the rising clock edge. A read returns the word on the next edge, and the read data register holds its value until the next read on that port.

The top two words serve as mailboxes when `mbox_en` is high. A right-port write to 0x3FE raises the left port's interrupt. A left-port write to 0x3FF raises the right port's interrupt. The receiving port drops its own interrupt by accessing its mailbox word with enable and output enable both high, whether it reads or writes. The word in each mailbox is ordinary data. When `mbox_en` is low, both words act as plain memory and neither interrupt is ever asserted.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: After reset both interrupt outputs are high (deasserted) and both read data outputs are 0x00.
- R2: A read (enable=1, output enable=1, write select=0) returns the stored word on the read data output after the next rising edge. Read data holds its value in every cycle without a read on that port.
- R3: Both ports may access different addresses in the same cycle without affecting each other.
- R4: With `mbox_en`=1, a right-port write to 0x3FE drives `l_irq_n` low after that edge.
- R5: The left interrupt returns high after an edge at which the left port has enable=1, output enable=1 and address 0x3FE, for either level of write select. Enable=1 with output enable=0 does not clear it.
- R6: With `mbox_en`=1, a left-port write to 0x3FF drives `r_irq_n` low after that edge. A right-port access to 0x3FF with enable and output enable high clears it.
- R7: Mailbox words store and return 8-bit data like any other word.
- R8: While `mbox_en`=0, no interrupt is raised. Any pending flag drops after the next edge, and 0x3FE and 0x3FF act as ordinary memory.
- R9: A port with enable=0 writes nothing, returns no read, and does not change either interrupt.
- R10: When a flag is set and cleared at the same edge, the set wins and the interrupt stays low.
- R11: When both ports write one address at the same edge, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | Enables the mailbox interrupt function |
| l_en | input | 1 | Left port enable |
| l_oe | input | 1 | Left port output enable |
| l_wr | input | 1 | Left port write select (1 = write) |
| l_addr | input | 10 | Left port address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port registered read data |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_oe | input | 1 | Right port output enable |
| r_wr | input | 1 | Right port write select (1 = write) |
| r_addr | input | 10 | Right port address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port registered read data |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The assertions check the flag rules on every edge: raising on a mailbox write, set-over-clear priority, clearing on a qualifying access, forced deassertion while the mailbox function is off, and flag stability when no event occurs. They also check that read data holds between reads. Properties cannot show the memory contents. Stored values, one-cycle read latency, port independence, left-wins collisions and mailbox data integrity rest on the bench's reference model, which runs through directed scenarios and a seeded random mix of mailbox and ordinary addresses.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  // Address of the mailbox word that belongs to a side (0 = left, 1 = right).
  function automatic int unsigned mbox_slot(input int unsigned aw, input int unsigned side);
    return (32'd1 << aw) - 32'd2 + side;
  endfunction

  // Next value of a mailbox flag; a set outranks a clear.
  function automatic logic flag_next(input logic enable, input logic set_evt,
                                     input logic clr_evt, input logic cur);
    if (!enable)      return 1'b0;
    else if (set_evt) return 1'b1;
    else if (clr_evt) return 1'b0;
    else              return cur;
  endfunction

endpackage

// File: rtl/dpm_store.sv
module dpm_store #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_we,
  input  logic          l_re,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  input  logic          r_we,
  input  logic          r_re,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Right write first, left write last: left wins on a shared address.
  always_ff @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wdata;
    if (l_we) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_re) l_rdata <= mem[l_addr];
      if (r_re) r_rdata <= mem[r_addr];
    end
  end

  assert_l_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !l_re |=> $stable(l_rdata));
  assert_r_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !r_re |=> $stable(r_rdata));

endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq_n
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= dpm_pkg::flag_next(enable, set_evt, clr_evt, flag_q);
  end

  assign irq_n = ~flag_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    enable && set_evt |=> !irq_n);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enable && clr_evt && !set_evt |=> irq_n);
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> irq_n);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !set_evt && !clr_evt |=> $stable(irq_n));

endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mbox_en,
  input  logic          l_en,
  input  logic          l_oe,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_en,
  input  logic          r_oe,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);
  localparam logic [AW-1:0] MB_L = AW'(dpm_pkg::mbox_slot(AW, 0));
  localparam logic [AW-1:0] MB_R = AW'(dpm_pkg::mbox_slot(AW, 1));

  // Named per-port events
  logic l_we, l_re, r_we, r_re;
  assign l_we = l_en & l_wr;
  assign r_we = r_en & r_wr;
  assign l_re = l_en & l_oe & ~l_wr;
  assign r_re = r_en & r_oe & ~r_wr;

  // Flag events, index 0 = left interrupt, 1 = right interrupt
  logic [1:0] set_v, clr_v, irq_v;
  assign set_v[0] = r_we && (r_addr == MB_L);
  assign clr_v[0] = l_en && l_oe && (l_addr == MB_L);
  assign set_v[1] = l_we && (l_addr == MB_R);
  assign clr_v[1] = r_en && r_oe && (r_addr == MB_R);

  dpm_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .l_we(l_we), .l_re(l_re), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_we(r_we), .r_re(r_re), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  for (genvar s = 0; s < 2; s++) begin : g_flag
    dpm_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .enable(mbox_en),
      .set_evt(set_v[s]), .clr_evt(clr_v[s]), .irq_n(irq_v[s])
    );
  end

  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];

  assert_left_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_en && r_en && r_wr && (r_addr == MB_L) |=> !l_irq_n);
  assert_right_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_en && l_en && l_wr && (l_addr == MB_R) |=> !r_irq_n);
  assert_idle_ports_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_en && !l_en && !r_en |=> $stable(l_irq_n) && $stable(r_irq_n));

endmodule

// File: tb/dpm_mailbox_ram_bench.sv
module dpm_mailbox_ram_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] MBL = 10'h3FE;
  localparam logic [9:0] MBR = 10'h3FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mbox_en = 1'b0;
  logic l_en = 0, l_oe = 0, l_wr = 0, r_en = 0, r_oe = 0, r_wr = 0;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_wdata = '0, r_wdata = '0;
  logic [7:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] ref_mem [1024];
  logic [7:0] exp_l = 8'h00, exp_r = 8'h00;
  logic flag_l = 1'b0, flag_r = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpm_mailbox_ram u_dpm_mailbox_ram (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .l_en(l_en), .l_oe(l_oe), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_oe(r_oe), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  function automatic logic model_flag(logic en, logic set, logic clr, logic cur);
    if (!en) return 1'b0;
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at negedge, update model at posedge, compare at next negedge.
  task automatic cyc(logic le, logic lo, logic lw, logic [9:0] la, logic [7:0] ld,
                     logic re, logic ro, logic rw, logic [9:0] ra, logic [7:0] rd);
    logic sl, cl, sr, cr;
    l_en = le; l_oe = lo; l_wr = lw; l_addr = la; l_wdata = ld;
    r_en = re; r_oe = ro; r_wr = rw; r_addr = ra; r_wdata = rd;
    @(posedge clk);
    if (le && lo && !lw) exp_l = ref_mem[la];
    if (re && ro && !rw) exp_r = ref_mem[ra];
    if (re && rw) ref_mem[ra] = rd;
    if (le && lw) ref_mem[la] = ld;
    sl = re && rw && (ra == MBL);
    cl = le && lo && (la == MBL);
    sr = le && lw && (la == MBR);
    cr = re && ro && (ra == MBR);
    flag_l = model_flag(mbox_en, sl, cl, flag_l);
    flag_r = model_flag(mbox_en, sr, cr, flag_r);
    @(negedge clk);
    check("R2 l_rdata", l_rdata, exp_l);
    check("R3 r_rdata", r_rdata, exp_r);
    check("R4 l_irq_n", {7'd0, l_irq_n}, {7'd0, ~flag_l});
    check("R6 r_irq_n", {7'd0, r_irq_n}, {7'd0, ~flag_r});
  endtask

  task automatic idle();
    cyc(0,0,0,10'h0,8'h0, 0,0,0,10'h0,8'h0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 l_irq_n", {7'd0, l_irq_n}, 8'd1);
    check("R1 r_irq_n", {7'd0, r_irq_n}, 8'd1);
    check("R1 l_rdata", l_rdata, 8'h00);
    check("R1 r_rdata", r_rdata, 8'h00);
    rst_n = 1'b1;
    mbox_en = 1'b1;
    @(negedge clk);

    // R2: write then read, then hold
    cyc(1,0,1,10'h010,8'hA5, 0,0,0,10'h0,8'h0);
    cyc(1,1,0,10'h010,8'h00, 0,0,0,10'h0,8'h0);
    check("R2 read latency", l_rdata, 8'hA5);
    idle();
    check("R2 hold", l_rdata, 8'hA5);

    // R3: simultaneous independent accesses
    cyc(1,0,1,10'h020,8'h11, 1,0,1,10'h021,8'h22);
    cyc(1,1,0,10'h021,8'h00, 1,1,0,10'h020,8'h00);
    check("R3 left sees right data", l_rdata, 8'h22);
    check("R3 right sees left data", r_rdata, 8'h11);

    // R11: collision, left wins
    cyc(1,0,1,10'h030,8'hAA, 1,0,1,10'h030,8'h55);
    cyc(0,0,0,10'h0,8'h0, 1,1,0,10'h030,8'h00);
    check("R11 left wins", r_rdata, 8'hAA);

    // R4: right writes left mailbox
    cyc(0,0,0,10'h0,8'h0, 1,0,1,MBL,8'h77);
    check("R4 left irq low", {7'd0, l_irq_n}, 8'd0);
    check("R4 right irq high", {7'd0, r_irq_n}, 8'd1);

    // R9: disabled left port cannot clear or write
    cyc(0,1,1,MBL,8'hEE, 0,0,0,10'h0,8'h0);
    check("R9 irq unchanged", {7'd0, l_irq_n}, 8'd0);
    // R5: enable without output enable does not clear
    cyc(1,0,0,MBL,8'h00, 0,0,0,10'h0,8'h0);
    check("R5 oe low keeps irq", {7'd0, l_irq_n}, 8'd0);
    // R5 and R7: read clears, data intact
    cyc(1,1,0,MBL,8'h00, 0,0,0,10'h0,8'h0);
    check("R5 read clears", {7'd0, l_irq_n}, 8'd1);
    check("R7 mailbox data", l_rdata, 8'h77);
    // R5: write-access also clears
    cyc(0,0,0,10'h0,8'h0, 1,0,1,MBL,8'h81);
    cyc(1,1,1,MBL,8'h78, 0,0,0,10'h0,8'h0);
    check("R5 write access clears", {7'd0, l_irq_n}, 8'd1);
    cyc(0,0,0,10'h0,8'h0, 1,1,0,MBL,8'h00);
    check("R7 mailbox rewrite", r_rdata, 8'h78);

    // R6: left writes right mailbox, right read clears
    cyc(1,0,1,MBR,8'h3C, 0,0,0,10'h0,8'h0);
    check("R6 right irq low", {7'd0, r_irq_n}, 8'd0);
    cyc(0,0,0,10'h0,8'h0, 1,1,0,MBR,8'h00);
    check("R6 right cleared", {7'd0, r_irq_n}, 8'd1);
    check("R6 R7 right data", r_rdata, 8'h3C);

    // R10: set and clear in the same cycle
    cyc(1,1,0,MBL,8'h00, 1,0,1,MBL,8'h5A);
    check("R10 set wins", {7'd0, l_irq_n}, 8'd0);
    check("R10 old data read", l_rdata, 8'h78);

    // R8: disabling drops the pending flag, no new set
    mbox_en = 1'b0;
    idle();
    check("R8 flag dropped", {7'd0, l_irq_n}, 8'd1);
    cyc(1,0,1,MBR,8'h99, 1,0,1,MBL,8'h66);
    check("R8 no left irq", {7'd0, l_irq_n}, 8'd1);
    check("R8 no right irq", {7'd0, r_irq_n}, 8'd1);
    cyc(1,1,0,MBL,8'h00, 1,1,0,MBR,8'h00);
    check("R8 plain memory left", l_rdata, 8'h66);
    check("R8 plain memory right", r_rdata, 8'h99);
    mbox_en = 1'b1;
    idle();

    // Random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] la, ra;
      int sel;
      sel = $urandom % 8;
      la = (sel == 0) ? MBL : (sel == 1) ? MBR : 10'(10'h040 + ($urandom % 16));
      sel = $urandom % 8;
      ra = (sel == 0) ? MBL : (sel == 1) ? MBR : 10'(10'h040 + ($urandom % 16));
      mbox_en = (($urandom % 16) != 0);
      cyc(1'($urandom), 1'($urandom), 1'($urandom), la, 8'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), ra, 8'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule